// File: doc/BRIEF.md
# Ethernet MAC Control Register

This block is the main control register of an Ethernet MAC. It is a single 32-bit word on a simple register bus with address, write enable, write data and read data. Some bits are level controls that stay set until software clears them: transmit enable, receive enable, local loopback, management port enable, statistics write enable, back pressure, receive timestamp storage and priority pause reception. The other bits are commands. Writing a one to a command bit produces a single-cycle strobe toward the transmitter, the receive buffer or the statistics block. Command bits always read back as zero.

The block also drives side effects from the level bits. Clearing transmit enable resets the transmit queue pointer and clears the transmit pipeline. Clearing receive enable clears only the receive pipeline. Clearing management enable puts the MDIO pin in its high-impedance state. Back pressure is passed on only while the link runs at 10 or 100 Mb/s half duplex.

A halt command is held as pending until the transmitter reports the end of a frame. The block then reports a halted state, which lasts until the next start command. A flush request for the next stored packet is accepted only while the DMA is not moving a stored packet to memory.

Top module: `mac_ctrl_reg`

## Requirements
- R1: After reset, read data is 0x00000000, every level output, strobe and side-effect pulse is 0, halt_pending and tx_halted are 0, and mdio_hiz is 1.
- R2: The level bits sit at these positions: loopback 1, rx enable 2, tx enable 3, management enable 4, statistics write enable 7, back pressure 8, timestamp store 15, priority pause receive 16. Each one reads back as written. Reserved bits and command bits always read 0, so writing 0xFFFFFFFF reads back 0x0001819E.
- R3: Writing 1 to a command bit drives its strobe high for exactly the one cycle after the write edge. The command bits are: clear statistics 5, increment statistics 6, start 9, pause frame 11, zero-quantum pause 12, priority pause 17. Writing 0 to a command bit gives no strobe.
- R4: The register answers only at offset 0x00. A write to any other address changes nothing and strobes nothing, and a read of any other address returns 0.
- R5: A write that takes tx enable from 1 to 0 pulses tx_qptr_rst and tx_pipe_clr for exactly one cycle after the write edge. A write that leaves tx enable at 0 or at 1 gives no pulse.
- R6: A write that takes rx enable from 1 to 0 pulses rx_pipe_clr for one cycle. It does not pulse tx_qptr_rst.
- R7: Writing 1 to bit 10 (halt) sets halt_pending. halt_pending stays set until tx_frame_end is sampled high on a later edge. On that edge halt_pending clears and tx_halted sets. A start command clears tx_halted, and also clears halt_pending unless halt is written in the same word. The two flags are never high together.
- R8: mdio_hiz is the inverse of management enable.
- R9: backpressure_force is high only when the back-pressure bit is 1, link_half_duplex is 1 and link_gigabit is 0.
- R10: Writing 1 to bit 18 (flush next packet) strobes rx_flush_stb for one cycle if dma_storing is 0 during the write. If dma_storing is 1, the request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| tx_frame_end | input | 1 | Transmitter finished a frame |
| dma_storing | input | 1 | DMA is moving a stored packet to memory |
| link_half_duplex | input | 1 | Link is half duplex |
| link_gigabit | input | 1 | Link runs at gigabit speed |
| tx_enable | output | 1 | Transmit enable level |
| rx_enable | output | 1 | Receive enable level |
| loop_local | output | 1 | Internal loopback level |
| mgmt_enable | output | 1 | Management port enable level |
| stats_wr_enable | output | 1 | Statistics counters writable |
| backpressure_force | output | 1 | Force collisions on receive |
| rx_stamp_store | output | 1 | Replace receive CRC with timestamp |
| prio_pause_rx_en | output | 1 | Recognise priority pause frames |
| tx_start_stb | output | 1 | Start transmission strobe |
| tx_pause_stb | output | 1 | Send pause frame strobe |
| tx_zq_pause_stb | output | 1 | Send zero-quantum pause strobe |
| tx_prio_pause_stb | output | 1 | Send priority pause strobe |
| rx_flush_stb | output | 1 | Flush next stored packet strobe |
| stats_inc_stb | output | 1 | Increment all statistics strobe |
| stats_clr_stb | output | 1 | Clear all statistics strobe |
| halt_pending | output | 1 | Halt waiting for frame end |
| tx_halted | output | 1 | Transmitter halted |
| tx_qptr_rst | output | 1 | Reset transmit queue pointer pulse |
| tx_pipe_clr | output | 1 | Clear transmit pipeline pulse |
| rx_pipe_clr | output | 1 | Clear receive pipeline pulse |
| mdio_hiz | output | 1 | MDIO output to high impedance |

## Verification
Level bits and read data change at the write edge and are sampled at the falling edge that follows. Strobes and enable-fall pulses are registered: they are high in the cycle after the write edge, and the bench checks them there and again one cycle later for the return to zero. The halt flags move one edge after tx_frame_end is sampled. Back pressure and MDIO control are combinational from the stored bits, so they are checked shortly after the link inputs change, with no clock edge in between.

// File: rtl/mac_ctrl_pkg.sv
package mac_ctrl_pkg;
  localparam int unsigned CTRL_W = 32;

  // level bit positions
  localparam int unsigned P_LOOP    = 1;
  localparam int unsigned P_RXEN    = 2;
  localparam int unsigned P_TXEN    = 3;
  localparam int unsigned P_MGMT    = 4;
  localparam int unsigned P_STWEN   = 7;
  localparam int unsigned P_BP      = 8;
  localparam int unsigned P_TSTAMP  = 15;
  localparam int unsigned P_PRIORX  = 16;

  // command bit positions
  localparam int unsigned P_STCLR   = 5;
  localparam int unsigned P_STINC   = 6;
  localparam int unsigned P_START   = 9;
  localparam int unsigned P_HALT    = 10;
  localparam int unsigned P_PAUSE   = 11;
  localparam int unsigned P_ZQPAUSE = 12;
  localparam int unsigned P_PRIOTX  = 17;
  localparam int unsigned P_FLUSH   = 18;

  // strobe vector indices
  localparam int unsigned S_STCLR   = 0;
  localparam int unsigned S_STINC   = 1;
  localparam int unsigned S_START   = 2;
  localparam int unsigned S_PAUSE   = 3;
  localparam int unsigned S_ZQPAUSE = 4;
  localparam int unsigned S_PRIOTX  = 5;
  localparam int unsigned S_FLUSH   = 6;
  localparam int unsigned NUM_STB   = 7;

  typedef struct packed {
    logic prio_rx;
    logic tstamp;
    logic bp;
    logic stat_wen;
    logic mgmt;
    logic txen;
    logic rxen;
    logic loopb;
  } level_t;

  function automatic level_t unpack_level(input logic [CTRL_W-1:0] w);
    level_t l;
    l.loopb    = w[P_LOOP];
    l.rxen     = w[P_RXEN];
    l.txen     = w[P_TXEN];
    l.mgmt     = w[P_MGMT];
    l.stat_wen = w[P_STWEN];
    l.bp       = w[P_BP];
    l.tstamp   = w[P_TSTAMP];
    l.prio_rx  = w[P_PRIORX];
    return l;
  endfunction

  function automatic logic [CTRL_W-1:0] pack_level(input level_t l);
    logic [CTRL_W-1:0] w;
    w           = '0;
    w[P_LOOP]   = l.loopb;
    w[P_RXEN]   = l.rxen;
    w[P_TXEN]   = l.txen;
    w[P_MGMT]   = l.mgmt;
    w[P_STWEN]  = l.stat_wen;
    w[P_BP]     = l.bp;
    w[P_TSTAMP] = l.tstamp;
    w[P_PRIORX] = l.prio_rx;
    return w;
  endfunction
endpackage

// File: rtl/ctrl_level_reg.sv
module ctrl_level_reg
  import mac_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output level_t            level_q,
  output logic              tx_fall_q,
  output logic              rx_fall_q
);
  level_t level_d;
  logic   tx_fall_d, rx_fall_d;

  always_comb begin
    level_d   = level_q;
    tx_fall_d = 1'b0;
    rx_fall_d = 1'b0;
    if (wr_en) begin
      level_d   = unpack_level(wdata);
      tx_fall_d = level_q.txen & ~level_d.txen;
      rx_fall_d = level_q.rxen & ~level_d.rxen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q   <= '0;
      tx_fall_q <= 1'b0;
      rx_fall_q <= 1'b0;
    end else begin
      if (wr_en) level_q <= level_d;
      tx_fall_q <= tx_fall_d;
      rx_fall_q <= rx_fall_d;
    end
  end

  assert_txfall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fall_q |-> (!level_q.txen && $past(level_q.txen)));
  assert_rxfall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fall_q |-> (!level_q.rxen && $past(level_q.rxen)));
endmodule

// File: rtl/ctrl_cmd_pulse.sv
module ctrl_cmd_pulse #(
  parameter int unsigned N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fire,
  output logic [N-1:0] stb_q
);
  for (genvar i = 0; i < N; i++) begin : g_stb
    logic stb_d;
    always_comb stb_d = fire[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[i] <= 1'b0;
      else        stb_q[i] <= stb_d;
    end
  end
endmodule

// File: rtl/ctrl_halt_track.sv
module ctrl_halt_track (
  input  logic clk,
  input  logic rst_n,
  input  logic halt_req,
  input  logic start_req,
  input  logic frame_end,
  output logic pending,
  output logic halted
);
  typedef enum logic [1:0] {H_RUN = 2'd0, H_WAIT = 2'd1, H_STOP = 2'd2} hstate_t;
  hstate_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      H_RUN:  if (halt_req) st_d = H_WAIT;
      H_WAIT: if (halt_req) st_d = H_WAIT;
              else if (start_req) st_d = H_RUN;
              else if (frame_end) st_d = H_STOP;
      H_STOP: if (halt_req) st_d = H_WAIT;
              else if (start_req) st_d = H_RUN;
      default: st_d = H_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= H_RUN;
    else        st_q <= st_d;
  end

  assign pending = (st_q == H_WAIT);
  assign halted  = (st_q == H_STOP);

  assert_halt_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(pending && frame_end));
  assert_halt_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && halted));
endmodule

// File: rtl/mac_ctrl_reg.sv
module mac_ctrl_reg
  import mac_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned REG_OFFSET = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_frame_end,
  input  logic              dma_storing,
  input  logic              link_half_duplex,
  input  logic              link_gigabit,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              loop_local,
  output logic              mgmt_enable,
  output logic              stats_wr_enable,
  output logic              backpressure_force,
  output logic              rx_stamp_store,
  output logic              prio_pause_rx_en,
  output logic              tx_start_stb,
  output logic              tx_pause_stb,
  output logic              tx_zq_pause_stb,
  output logic              tx_prio_pause_stb,
  output logic              rx_flush_stb,
  output logic              stats_inc_stb,
  output logic              stats_clr_stb,
  output logic              halt_pending,
  output logic              tx_halted,
  output logic              tx_qptr_rst,
  output logic              tx_pipe_clr,
  output logic              rx_pipe_clr,
  output logic              mdio_hiz
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic               hit, wr_hit;
  level_t             lvl;
  logic               tx_fall, rx_fall;
  logic [NUM_STB-1:0] fire, stb;

  assign hit    = (reg_addr == OFFS);
  assign wr_hit = reg_we & hit;

  always_comb begin
    fire            = '0;
    fire[S_STCLR]   = wr_hit & reg_wdata[P_STCLR];
    fire[S_STINC]   = wr_hit & reg_wdata[P_STINC];
    fire[S_START]   = wr_hit & reg_wdata[P_START];
    fire[S_PAUSE]   = wr_hit & reg_wdata[P_PAUSE];
    fire[S_ZQPAUSE] = wr_hit & reg_wdata[P_ZQPAUSE];
    fire[S_PRIOTX]  = wr_hit & reg_wdata[P_PRIOTX];
    fire[S_FLUSH]   = wr_hit & reg_wdata[P_FLUSH] & ~dma_storing;
  end

  ctrl_level_reg u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_hit),
    .wdata     (reg_wdata),
    .level_q   (lvl),
    .tx_fall_q (tx_fall),
    .rx_fall_q (rx_fall)
  );

  ctrl_cmd_pulse #(.N(NUM_STB)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .stb_q (stb)
  );

  ctrl_halt_track u_halt (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_req  (wr_hit & reg_wdata[P_HALT]),
    .start_req (wr_hit & reg_wdata[P_START]),
    .frame_end (tx_frame_end),
    .pending   (halt_pending),
    .halted    (tx_halted)
  );

  assign reg_rdata          = hit ? pack_level(lvl) : '0;
  assign tx_enable          = lvl.txen;
  assign rx_enable          = lvl.rxen;
  assign loop_local         = lvl.loopb;
  assign mgmt_enable        = lvl.mgmt;
  assign stats_wr_enable    = lvl.stat_wen;
  assign rx_stamp_store     = lvl.tstamp;
  assign prio_pause_rx_en   = lvl.prio_rx;
  assign backpressure_force = lvl.bp & link_half_duplex & ~link_gigabit;
  assign mdio_hiz           = ~lvl.mgmt;
  assign tx_qptr_rst        = tx_fall;
  assign tx_pipe_clr        = tx_fall;
  assign rx_pipe_clr        = rx_fall;
  assign stats_clr_stb      = stb[S_STCLR];
  assign stats_inc_stb      = stb[S_STINC];
  assign tx_start_stb       = stb[S_START];
  assign tx_pause_stb       = stb[S_PAUSE];
  assign tx_zq_pause_stb    = stb[S_ZQPAUSE];
  assign tx_prio_pause_stb  = stb[S_PRIOTX];
  assign rx_flush_stb       = stb[S_FLUSH];

  assert_start_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_stb |-> $past(reg_we && reg_addr == OFFS && reg_wdata[P_START]));
  assert_flush_idle_dma_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush_stb |-> $past(!dma_storing && reg_we));
  assert_bp_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    backpressure_force |-> (link_half_duplex && !link_gigabit));
  assert_offset_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != OFFS) |=> $stable(tx_enable) && !tx_start_stb);
  always_comb begin
    if (rst_n && !hit) assert_rd_miss_R4: assert (reg_rdata == '0);
  end
endmodule

// File: tb/mac_ctrl_reg_test.sv
`timescale 1ns/1ps
module mac_ctrl_reg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic tx_frame_end, dma_storing, link_half_duplex, link_gigabit;
  logic tx_enable, rx_enable, loop_local, mgmt_enable, stats_wr_enable;
  logic backpressure_force, rx_stamp_store, prio_pause_rx_en;
  logic tx_start_stb, tx_pause_stb, tx_zq_pause_stb, tx_prio_pause_stb;
  logic rx_flush_stb, stats_inc_stb, stats_clr_stb;
  logic halt_pending, tx_halted, tx_qptr_rst, tx_pipe_clr, rx_pipe_clr, mdio_hiz;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  mac_ctrl_reg uut (.*);

  // strobe vector: [0]clr [1]inc [2]start [3]pause [4]zq [5]prio [6]flush
  function automatic logic [6:0] stb_vec();
    return {rx_flush_stb, tx_prio_pause_stb, tx_zq_pause_stb, tx_pause_stb,
            tx_start_stb, stats_inc_stb, stats_clr_stb};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 8'h00; reg_wdata = '0;
    #0.1;
  endtask

  // {addr, wdata, expected read at offset 0, expected strobe vector}
  localparam logic [78:0] VEC [8] = '{
    {8'h00, 32'h0000_0004, 32'h0000_0004, 7'h00},
    {8'h00, 32'hFFFF_FFFF, 32'h0001_819E, 7'h7F},
    {8'h00, 32'h0000_0000, 32'h0000_0000, 7'h00},
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0000, 7'h00},
    {8'h00, 32'h0000_0200, 32'h0000_0000, 7'h04},
    {8'h00, 32'h0002_0000, 32'h0000_0000, 7'h20},
    {8'h00, 32'h0000_1860, 32'h0000_0000, 7'h1B},
    {8'h00, 32'h0000_8110, 32'h0000_8110, 7'h00}
  };

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
    tx_frame_end = 1'b0; dma_storing = 1'b0;
    link_half_duplex = 1'b0; link_gigabit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
    check(stb_vec() == 7'h0, "R1 strobes", {25'h0, stb_vec()}, 32'h0);
    check({tx_enable, rx_enable, loop_local, mgmt_enable, stats_wr_enable,
           rx_stamp_store, prio_pause_rx_en, backpressure_force} == 8'h0,
          "R1 levels", 32'h0, 32'h0);
    check(!halt_pending && !tx_halted && !tx_qptr_rst && !rx_pipe_clr,
          "R1 halt/pulses", {28'h0, halt_pending, tx_halted, tx_qptr_rst, rx_pipe_clr}, 32'h0);
    check(mdio_hiz == 1'b1, "R1 mdio_hiz", {31'h0, mdio_hiz}, 32'h1);

    // table walk: R2 R3 R4
    foreach (VEC[i]) begin
      write(VEC[i][78:71], VEC[i][70:39]);
      check(reg_rdata == VEC[i][38:7], "R2/R4 vector rdata", reg_rdata, VEC[i][38:7]);
      check(stb_vec() == VEC[i][6:0], "R3/R4 vector strobes",
            {25'h0, stb_vec()}, {25'h0, VEC[i][6:0]});
    end

    // R3 strobe lasts exactly one cycle
    write(8'h00, 32'h0000_0A00 & 32'h0000_0200);
    check(tx_start_stb == 1'b1, "R3 start high", {31'h0, tx_start_stb}, 32'h1);
    @(negedge clk);
    check(tx_start_stb == 1'b0, "R3 start one cycle", {31'h0, tx_start_stb}, 32'h0);

    // R4 read of another offset returns 0
    write(8'h00, 32'h0000_0008);
    reg_addr = 8'h08; #0.1;
    check(reg_rdata == 32'h0, "R4 miss read", reg_rdata, 32'h0);
    reg_addr = 8'h00; #0.1;

    // R5 tx enable fall
    write(8'h00, 32'h0000_0008);
    check(!tx_qptr_rst && !tx_pipe_clr, "R5 no pulse on 1->1",
          {30'h0, tx_qptr_rst, tx_pipe_clr}, 32'h0);
    write(8'h00, 32'h0000_0000);
    check(tx_qptr_rst && tx_pipe_clr && !rx_pipe_clr, "R5 pulse on 1->0",
          {29'h0, tx_qptr_rst, tx_pipe_clr, rx_pipe_clr}, 32'h6);
    @(negedge clk);
    check(!tx_qptr_rst, "R5 pulse one cycle", {31'h0, tx_qptr_rst}, 32'h0);
    write(8'h00, 32'h0000_0000);
    check(!tx_qptr_rst, "R5 no pulse on 0->0", {31'h0, tx_qptr_rst}, 32'h0);

    // R6 rx enable fall
    write(8'h00, 32'h0000_0004);
    write(8'h00, 32'h0000_0000);
    check(rx_pipe_clr && !tx_qptr_rst, "R6 rx clear only",
          {30'h0, rx_pipe_clr, tx_qptr_rst}, 32'h2);

    // R7 halt tracking
    write(8'h00, 32'h0000_0200);
    write(8'h00, 32'h0000_0400);
    check(halt_pending && !tx_halted, "R7 pending set",
          {30'h0, halt_pending, tx_halted}, 32'h2);
    repeat (3) @(negedge clk);
    check(halt_pending && !tx_halted, "R7 pending held",
          {30'h0, halt_pending, tx_halted}, 32'h2);
    tx_frame_end = 1'b1;
    @(negedge clk);
    tx_frame_end = 1'b0;
    check(!halt_pending && tx_halted, "R7 halted after frame end",
          {30'h0, halt_pending, tx_halted}, 32'h1);
    repeat (2) @(negedge clk);
    check(tx_halted, "R7 halted held", {31'h0, tx_halted}, 32'h1);
    write(8'h00, 32'h0000_0200);
    check(!tx_halted && !halt_pending, "R7 start clears",
          {30'h0, halt_pending, tx_halted}, 32'h0);
    write(8'h00, 32'h0000_0600);
    check(halt_pending, "R7 halt wins over start", {31'h0, halt_pending}, 32'h1);
    write(8'h00, 32'h0000_0200);
    check(!halt_pending, "R7 start cancels pending", {31'h0, halt_pending}, 32'h0);

    // R8 management / MDIO
    write(8'h00, 32'h0000_0010);
    check(!mdio_hiz, "R8 mdio driven", {31'h0, mdio_hiz}, 32'h0);
    write(8'h00, 32'h0000_0000);
    check(mdio_hiz, "R8 mdio hiz", {31'h0, mdio_hiz}, 32'h1);

    // R9 back pressure mode gating
    write(8'h00, 32'h0000_0100);
    check(!backpressure_force, "R9 full duplex", {31'h0, backpressure_force}, 32'h0);
    link_half_duplex = 1'b1; #0.1;
    check(backpressure_force, "R9 half 10/100", {31'h0, backpressure_force}, 32'h1);
    link_gigabit = 1'b1; #0.1;
    check(!backpressure_force, "R9 gigabit ignored", {31'h0, backpressure_force}, 32'h0);
    check(reg_rdata == 32'h0000_0100, "R9 bit kept", reg_rdata, 32'h0000_0100);
    link_gigabit = 1'b0; link_half_duplex = 1'b0;

    // R10 flush gated by DMA activity
    dma_storing = 1'b1;
    write(8'h00, 32'h0004_0000);
    check(!rx_flush_stb, "R10 flush dropped while DMA busy", {31'h0, rx_flush_stb}, 32'h0);
    dma_storing = 1'b0;
    write(8'h00, 32'h0004_0000);
    check(rx_flush_stb, "R10 flush accepted", {31'h0, rx_flush_stb}, 32'h1);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule